// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block makes the accept-or-drop decision for a received Ethernet frame from its 48-bit destination address alone, and picks the receive channel the frame is steered to. A strobe presents the address. One clock later the block returns a valid pulse, an accept flag, a 3-bit channel and a 2-bit frame class. Frame parsing, FCS and length checks, and buffer movement are handled by the neighbouring logic.

The block is configured through a write-only register port. The registers hold a policy word, the station address, a per-channel unicast enable mask, and a 64-entry multicast hash table. The policy word has one enable bit and one channel field for each of three classes: promiscuous, broadcast and multicast. The station address shares its first five bytes across all channels. The sixth byte is held separately for each channel, so up to eight station addresses can be told apart by their last byte. Multicast addresses are looked up in the hash table through a 6-bit index folded from the address bytes with XOR and shifts.

Top module: `rx_addr_filter`

## Requirements
- R1: `outValid` is high in exactly the cycle after each cycle with `dstValid` high. When `outValid` is low, `accept`, `chan` and `frameClass` are all 0. After reset all outputs are 0.
- R2: Address byte k (k = 0..5) is `dstAddr[47-8k -: 8]`, and byte 0 is first on the wire. An all-ones address is broadcast. An address whose byte 0 bit 0 (`dstAddr[40]`) is set, and which is not broadcast, is multicast. Every other address is unicast.
- R3: When policy bit 21 is set, every frame is accepted with class 3 (promiscuous) on the channel in policy bits 18:16. This rule overrides all other rules.
- R4: The station address for channel c is made of byte 0..3 from station-high bits 7:0, 15:8, 23:16, 31:24, byte 4 from station-mid bits 7:0, and byte 5 from bits 7:0 of the per-channel low register c. A frame whose address equals the station address of an enabled channel is accepted with class 0 on the lowest-numbered such channel. This rule comes after R3 and before R6 and R7.
- R5: The unicast enable mask resets to 0. Writing index 1 sets the mask bits where `wrData[7:0]` has ones. Writing index 2 clears the mask bits where `wrData[7:0]` has ones. A channel whose mask bit is clear never matches under R4.
- R6: A broadcast frame that no earlier rule takes is accepted with class 1 on the channel in policy bits 10:8, if policy bit 13 is set.
- R7: The hash index is the low 6 bits of an XOR over the six address bytes, with 8-bit shifts. Bytes 0 and 3 contribute (b>>2)^(b<<4). Bytes 1 and 4 contribute (b>>4)^(b<<2). Bytes 2 and 5 contribute (b>>6)^b. Index i < 32 selects bit i of hash-low (register 5). Index i >= 32 selects bit i-32 of hash-high (register 6). A multicast frame that no earlier rule takes is accepted with class 2 on the channel in policy bits 2:0 when policy bit 5 is set and the selected bit is 1.
- R8: A frame that no rule accepts has `accept` 0 and `chan` 0. Its `frameClass` is the address type from R2: 0 unicast, 1 broadcast, 2 multicast.
- R9: A register write in the same cycle as `dstValid` takes effect only for later frames. The decision for that frame uses the values held before the write.
- R10: The register indices are 0 policy, 1 mask set, 2 mask clear, 3 station-high, 4 station-mid, 5 hash-low, 6 hash-high, and 8+c station-low for channel c. A write to any other index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 4 | Register index |
| wrData | input | 32 | Register write data |
| dstValid | input | 1 | Destination address strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits 47:40 |
| outValid | output | 1 | Decision valid, one clock after the strobe |
| accept | output | 1 | Frame accepted |
| chan | output | 3 | Receive channel of the accepted frame |
| frameClass | output | 2 | 0 unicast, 1 broadcast, 2 multicast, 3 promiscuous |

## Verification
Directed frames cover each rule in turn. Unicast frames that differ only in the last byte show whether the per-channel byte and the mask are used, and whether the lowest channel wins when two channels share a byte. Two multicast addresses whose hash indices differ by one, and one whose index lies above 31, show whether the fold and the low/high table split are correct. Broadcast with its enable off but an all-ones hash table shows that broadcast is kept apart from multicast. Promiscuous mode applied to a matching unicast address shows the priority order. A random phase then mixes address types, near-miss station addresses and changing policy words, and checks every cycle against a behavioural model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int CH_W        = 3;
  localparam int IDX_W       = 4;
  localparam int LO_BASE     = 8;
  localparam int MAX_CH      = 8;

  localparam logic [IDX_W-1:0] REG_POLICY  = 4'd0;
  localparam logic [IDX_W-1:0] REG_UC_SET  = 4'd1;
  localparam logic [IDX_W-1:0] REG_UC_CLR  = 4'd2;
  localparam logic [IDX_W-1:0] REG_STA_HI  = 4'd3;
  localparam logic [IDX_W-1:0] REG_STA_MID = 4'd4;
  localparam logic [IDX_W-1:0] REG_HASH_LO = 4'd5;
  localparam logic [IDX_W-1:0] REG_HASH_HI = 4'd6;

  localparam int POL_PROM_EN = 21;
  localparam int POL_PROM_CH = 16;
  localparam int POL_BC_EN   = 13;
  localparam int POL_BC_CH   = 8;
  localparam int POL_MC_EN   = 5;
  localparam int POL_MC_CH   = 0;

  typedef enum logic [1:0] {
    CLS_UCAST   = 2'd0,
    CLS_BCAST   = 2'd1,
    CLS_MCAST   = 2'd2,
    CLS_PROMISC = 2'd3
  } frame_class_e;

  typedef struct packed {
    logic            promEn;
    logic [CH_W-1:0] promCh;
    logic            bcEn;
    logic [CH_W-1:0] bcCh;
    logic            mcEn;
    logic [CH_W-1:0] mcCh;
    logic [63:0]     hashTbl;
    logic [39:0]     staHigh;
  } filt_cfg_t;

  typedef struct packed {
    logic eval;
    logic cfgBusy;
  } filt_stb_t;

endpackage

// File: rtl/rxf_hash.sv
module rxf_hash (
  input  logic [47:0] addr,
  output logic [5:0]  idx
);
  logic [5:0][7:0] term;

  for (genvar i = 0; i < 6; i++) begin : g_term
    logic [7:0] b;
    assign b = addr[47-8*i -: 8];
    if (i % 3 == 0) begin : g_sh24
      assign term[i] = (b >> 2) ^ (b << 4);
    end else if (i % 3 == 1) begin : g_sh42
      assign term[i] = (b >> 4) ^ (b << 2);
    end else begin : g_sh60
      assign term[i] = (b >> 6) ^ b;
    end
  end

  logic [7:0] folded;
  always_comb begin
    folded = '0;
    for (int i = 0; i < 6; i++) folded = folded ^ term[i];
  end

  assign idx = folded[5:0];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [31:0]            wrData,
  input  logic                   dstValid,
  output filt_stb_t              stb,
  output filt_cfg_t              cfg,
  output logic [NUM_CH-1:0]      ucastMask,
  output logic [NUM_CH-1:0][7:0] staLow
);
  logic            promEnQ, bcEnQ, mcEnQ;
  logic [CH_W-1:0] promChQ, bcChQ, mcChQ;
  logic [31:0]     staHiQ, hashLoQ, hashHiQ;
  logic [7:0]      staMidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      promEnQ   <= 1'b0;
      bcEnQ     <= 1'b0;
      mcEnQ     <= 1'b0;
      promChQ   <= '0;
      bcChQ     <= '0;
      mcChQ     <= '0;
      staHiQ    <= '0;
      staMidQ   <= '0;
      hashLoQ   <= '0;
      hashHiQ   <= '0;
      ucastMask <= '0;
    end else if (wrEn) begin
      unique case (wrIdx)
        REG_POLICY: begin
          promEnQ <= wrData[POL_PROM_EN];
          promChQ <= wrData[POL_PROM_CH +: CH_W];
          bcEnQ   <= wrData[POL_BC_EN];
          bcChQ   <= wrData[POL_BC_CH +: CH_W];
          mcEnQ   <= wrData[POL_MC_EN];
          mcChQ   <= wrData[POL_MC_CH +: CH_W];
        end
        REG_UC_SET:  ucastMask <= ucastMask | wrData[NUM_CH-1:0];
        REG_UC_CLR:  ucastMask <= ucastMask & ~wrData[NUM_CH-1:0];
        REG_STA_HI:  staHiQ  <= wrData;
        REG_STA_MID: staMidQ <= wrData[7:0];
        REG_HASH_LO: hashLoQ <= wrData;
        REG_HASH_HI: hashHiQ <= wrData;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_low
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(LO_BASE + c);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        staLow[c] <= '0;
      else if (wrEn && wrIdx == MY_IDX) staLow[c] <= wrData[7:0];
    end
  end

  always_comb begin
    cfg.promEn  = promEnQ;
    cfg.promCh  = promChQ;
    cfg.bcEn    = bcEnQ;
    cfg.bcCh    = bcChQ;
    cfg.mcEn    = mcEnQ;
    cfg.mcCh    = mcChQ;
    cfg.hashTbl = {hashHiQ, hashLoQ};
    cfg.staHigh = {staHiQ[7:0], staHiQ[15:8], staHiQ[23:16], staHiQ[31:24], staMidQ};
    stb.eval    = dstValid;
    stb.cfgBusy = wrEn;
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  filt_stb_t              stb,
  input  filt_cfg_t              cfg,
  input  logic [NUM_CH-1:0]      ucastMask,
  input  logic [NUM_CH-1:0][7:0] staLow,
  input  logic [47:0]            dstAddr,
  output logic                   outValid,
  output logic                   accept,
  output logic [CH_W-1:0]        chan,
  output frame_class_e           frameClass
);
  logic       isBcast, isMcast, hashHit, highHit;
  logic [5:0] hashIdx;

  assign isBcast = &dstAddr;
  assign isMcast = dstAddr[40] && !isBcast;
  assign highHit = (dstAddr[47:8] == cfg.staHigh);

  rxf_hash uHash (
    .addr(dstAddr),
    .idx (hashIdx)
  );
  assign hashHit = cfg.hashTbl[hashIdx];

  logic [NUM_CH-1:0] chMatch;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign chMatch[c] = ucastMask[c] && highHit && (dstAddr[7:0] == staLow[c]);
  end

  logic            ucHit;
  logic [CH_W-1:0] ucCh;
  always_comb begin
    ucHit = 1'b0;
    ucCh  = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (chMatch[c]) begin
        ucHit = 1'b1;
        ucCh  = CH_W'(c);
      end
    end
  end

  logic            nAcc;
  logic [CH_W-1:0] nCh;
  frame_class_e    nCls;
  always_comb begin
    nAcc = 1'b0;
    nCh  = '0;
    nCls = isBcast ? CLS_BCAST : (isMcast ? CLS_MCAST : CLS_UCAST);
    if (cfg.promEn) begin
      nAcc = 1'b1;
      nCh  = cfg.promCh;
      nCls = CLS_PROMISC;
    end else if (ucHit) begin
      nAcc = 1'b1;
      nCh  = ucCh;
      nCls = CLS_UCAST;
    end else if (isBcast && cfg.bcEn) begin
      nAcc = 1'b1;
      nCh  = cfg.bcCh;
    end else if (isMcast && cfg.mcEn && hashHit) begin
      nAcc = 1'b1;
      nCh  = cfg.mcCh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      accept     <= 1'b0;
      chan       <= '0;
      frameClass <= CLS_UCAST;
    end else if (stb.eval) begin
      outValid   <= 1'b1;
      accept     <= nAcc;
      chan       <= nCh;
      frameClass <= nCls;
    end else begin
      outValid   <= 1'b0;
      accept     <= 1'b0;
      chan       <= '0;
      frameClass <= CLS_UCAST;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrIdx,
  input  logic [31:0] wrData,
  input  logic        dstValid,
  input  logic [47:0] dstAddr,
  output logic        outValid,
  output logic        accept,
  output logic [2:0]  chan,
  output logic [1:0]  frameClass
);
  filt_stb_t              stb;
  filt_cfg_t              cfg;
  logic [NUM_CH-1:0]      ucastMask;
  logic [NUM_CH-1:0][7:0] staLow;
  frame_class_e           clsOut;

  rxf_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .dstValid (dstValid),
    .stb      (stb),
    .cfg      (cfg),
    .ucastMask(ucastMask),
    .staLow   (staLow)
  );

  rxf_datapath #(.NUM_CH(NUM_CH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfg       (cfg),
    .ucastMask (ucastMask),
    .staLow    (staLow),
    .dstAddr   (dstAddr),
    .outValid  (outValid),
    .accept    (accept),
    .chan      (chan),
    .frameClass(clsOut)
  );

  assign frameClass = clsOut;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [31:0]       wrData,
  input logic              dstValid,
  input logic [47:0]       dstAddr,
  input logic              outValid,
  input logic              accept,
  input logic [2:0]        chan,
  input logic [1:0]        frameClass,
  input logic [NUM_CH-1:0] ucastMask
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    dstValid |=> outValid);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dstValid |=> !outValid);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!accept && chan == 3'd0 && frameClass == 2'd0));

  a_r8_reject_chan: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !accept) |-> (chan == 3'd0 && frameClass != 2'd3));

  a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && frameClass == 2'd3) |-> accept);

  a_r2_bcast_not_mcast: assert property (@(posedge clk) disable iff (!rstN)
    (dstValid && (&dstAddr)) |=> frameClass != 2'd2);

  a_r2_mcast_not_bcast: assert property (@(posedge clk) disable iff (!rstN)
    (dstValid && dstAddr[40] && !(&dstAddr)) |=> frameClass != 2'd1);

  a_r5_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 4'd1) |=>
      ((ucastMask & $past(wrData[NUM_CH-1:0])) == $past(wrData[NUM_CH-1:0])));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 4'd2) |=> ((ucastMask & $past(wrData[NUM_CH-1:0])) == '0));
endmodule

bind rx_addr_filter rxf_checker #(.NUM_CH(NUM_CH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrData    (wrData),
  .dstValid  (dstValid),
  .dstAddr   (dstAddr),
  .outValid  (outValid),
  .accept    (accept),
  .chan      (chan),
  .frameClass(frameClass),
  .ucastMask (ucastMask)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        dstValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic        outValid, accept;
  logic [2:0]  chan;
  logic [1:0]  frameClass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .dstValid(dstValid), .dstAddr(dstAddr), .outValid(outValid),
    .accept(accept), .chan(chan), .frameClass(frameClass)
  );

  // Reference model state
  logic [31:0] mPolicy, mHi, mHashLo, mHashHi;
  logic [7:0]  mMid, mMask;
  logic [7:0]  mLow [8];
  logic        eV, eA;
  logic [2:0]  eC;
  logic [1:0]  eK;
  string       eTag;

  function automatic logic [5:0] refHash(input logic [47:0] a);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = a[47-8*i -: 8];
      if (i == 0 || i == 3)      acc = acc ^ (b >> 2) ^ 8'(b << 4);
      else if (i == 1 || i == 4) acc = acc ^ (b >> 4) ^ 8'(b << 2);
      else                       acc = acc ^ (b >> 6) ^ b;
    end
    return acc[5:0];
  endfunction

  task automatic refDecide(input logic [47:0] a, output logic acc,
                           output logic [2:0] ch, output logic [1:0] k,
                           output string tag);
    logic bc, mc, hit;
    logic [63:0] tbl;
    int ucFound;
    logic [7:0] st [6];
    bc = (a == 48'hFFFF_FFFF_FFFF);
    mc = a[40] && !bc;
    tbl = {mHashHi, mHashLo};
    hit = tbl[refHash(a)];
    st[0] = mHi[7:0]; st[1] = mHi[15:8]; st[2] = mHi[23:16]; st[3] = mHi[31:24];
    st[4] = mMid;
    ucFound = -1;
    for (int c = 0; c < 8; c++) begin
      st[5] = mLow[c];
      if (ucFound < 0 && mMask[c] &&
          a == {st[0], st[1], st[2], st[3], st[4], st[5]}) ucFound = c;
    end
    acc = 1'b0; ch = 3'd0; k = bc ? 2'd1 : (mc ? 2'd2 : 2'd0); tag = "R8";
    if (mPolicy[21]) begin
      acc = 1'b1; ch = mPolicy[18:16]; k = 2'd3; tag = "R3";
    end else if (ucFound >= 0) begin
      acc = 1'b1; ch = 3'(ucFound); k = 2'd0; tag = "R4";
    end else if (bc && mPolicy[13]) begin
      acc = 1'b1; ch = mPolicy[10:8]; tag = "R6";
    end else if (mc && mPolicy[5] && hit) begin
      acc = 1'b1; ch = mPolicy[2:0]; tag = "R7";
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPolicy = '0; mHi = '0; mHashLo = '0; mHashHi = '0; mMid = '0; mMask = '0;
      for (int c = 0; c < 8; c++) mLow[c] = '0;
      eV <= 1'b0; eA <= 1'b0; eC <= '0; eK <= '0; eTag <= "R1";
    end else begin
      logic a; logic [2:0] c3; logic [1:0] k; string t;
      if (dstValid) begin
        refDecide(dstAddr, a, c3, k, t);
        eV <= 1'b1; eA <= a; eC <= c3; eK <= k; eTag <= t;
      end else begin
        eV <= 1'b0; eA <= 1'b0; eC <= '0; eK <= '0; eTag <= "R1";
      end
      // writes land after the decision (R9)
      if (wrEn) begin
        case (wrIdx)
          4'd0: mPolicy = wrData;
          4'd1: mMask = mMask | wrData[7:0];
          4'd2: mMask = mMask & ~wrData[7:0];
          4'd3: mHi = wrData;
          4'd4: mMid = wrData[7:0];
          4'd5: mHashLo = wrData;
          4'd6: mHashHi = wrData;
          default: if (wrIdx >= 4'd8) mLow[wrIdx - 4'd8] = wrData[7:0];
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1", "outValid", int'(outValid), int'(eV));
      chk(eTag, "accept", int'(accept), int'(eA));
      chk(eTag, "chan", int'(chan), int'(eC));
      chk(eV && !eA ? "R2" : eTag, "frameClass", int'(frameClass), int'(eK));
    end
  end

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input logic eAcc, input logic [2:0] eCh,
                       input logic [1:0] eCls, input string tag);
    @(negedge clk);
    dstValid = 1'b1; dstAddr = a;
    @(negedge clk);
    dstValid = 1'b0;
    #1;
    chk(tag, "directed accept", int'(accept), int'(eAcc));
    chk(tag, "directed chan", int'(chan), int'(eCh));
    chk(tag, "directed frameClass", int'(frameClass), int'(eCls));
  endtask

  localparam logic [47:0] UC_BASE = 48'h0211_2233_4400;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC_I14  = 48'h0100_5E00_0001; // index 14
  localparam logic [47:0] MC_I13  = 48'h0100_5E00_0002; // index 13
  localparam logic [47:0] MC_I46  = 48'h0100_5E00_0021; // index 46

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset outValid", int'(outValid), 0);
    chk("R1", "reset accept", int'(accept), 0);
    rstN = 1'b1;

    // No configuration: everything rejected, class is address type
    frame(UC_BASE | 48'h51, 1'b0, 3'd0, 2'd0, "R8");
    frame(BCAST, 1'b0, 3'd0, 2'd1, "R2");
    frame(MC_I14, 1'b0, 3'd0, 2'd2, "R2");

    // Station address and per-channel last byte
    regWrite(4'd3, 32'h3322_1102);
    regWrite(4'd4, 32'h0000_0044);
    for (int c = 0; c < 8; c++) regWrite(4'(8 + c), 32'(8'h50 + c));
    regWrite(4'd1, 32'h0000_000A);
    frame(UC_BASE | 48'h51, 1'b1, 3'd1, 2'd0, "R4");
    frame(UC_BASE | 48'h53, 1'b1, 3'd3, 2'd0, "R4");
    frame(UC_BASE | 48'h52, 1'b0, 3'd0, 2'd0, "R5");

    // Shared last byte: lowest channel wins, then clear it
    regWrite(4'd13, 32'h51);
    regWrite(4'd1, 32'h20);
    frame(UC_BASE | 48'h51, 1'b1, 3'd1, 2'd0, "R4");
    regWrite(4'd2, 32'h02);
    frame(UC_BASE | 48'h51, 1'b1, 3'd5, 2'd0, "R5");

    // Write in the same cycle as the strobe
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'd1; wrData = 32'h04;
    dstValid = 1'b1; dstAddr = UC_BASE | 48'h52;
    @(negedge clk);
    wrEn = 1'b0; dstValid = 1'b0;
    #1;
    chk("R9", "same-cycle accept", int'(accept), 0);
    frame(UC_BASE | 48'h52, 1'b1, 3'd2, 2'd0, "R9");

    // Undefined index has no effect
    regWrite(4'd7, 32'hFFFF_FFFF);
    frame(UC_BASE | 48'h53, 1'b1, 3'd3, 2'd0, "R10");
    frame(BCAST, 1'b0, 3'd0, 2'd1, "R10");

    // Broadcast and multicast
    regWrite(4'd0, 32'h0000_2622);
    frame(BCAST, 1'b1, 3'd6, 2'd1, "R6");
    frame(MC_I14, 1'b0, 3'd0, 2'd2, "R7");
    regWrite(4'd5, 32'h0000_4000);
    frame(MC_I14, 1'b1, 3'd2, 2'd2, "R7");
    frame(MC_I13, 1'b0, 3'd0, 2'd2, "R7");
    regWrite(4'd5, 32'h0);
    regWrite(4'd6, 32'hFFFF_FFFF);
    frame(MC_I46, 1'b1, 3'd2, 2'd2, "R7");
    frame(MC_I14, 1'b0, 3'd0, 2'd2, "R7");
    regWrite(4'd6, 32'h0000_4000);
    frame(MC_I46, 1'b1, 3'd2, 2'd2, "R7");
    regWrite(4'd5, 32'hFFFF_FFFF);
    regWrite(4'd6, 32'hFFFF_FFFF);
    frame(48'h0B12_3456_7890, 1'b1, 3'd2, 2'd2, "R7");
    regWrite(4'd0, 32'h0000_0022);
    frame(BCAST, 1'b0, 3'd0, 2'd1, "R6");

    // Promiscuous overrides everything
    regWrite(4'd0, 32'h0024_2622);
    frame(UC_BASE | 48'h51, 1'b1, 3'd4, 2'd3, "R3");
    frame(48'h00AA_BBCC_DDEE, 1'b1, 3'd4, 2'd3, "R3");
    frame(BCAST, 1'b1, 3'd4, 2'd3, "R3");

    // Random phase, checked every cycle by the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wrEn = 1'b0;
      if (n % 40 == 0) begin
        wrEn = 1'b1; wrIdx = 4'd0;
        wrData = $urandom & 32'h0027_2727;
        if ($urandom % 2 == 0) wrData[21] = 1'b0;
      end else if (n % 40 == 20) begin
        wrEn = 1'b1; wrIdx = 4'(1 + $urandom % 2); wrData = $urandom;
      end else if (n % 40 == 30) begin
        wrEn = 1'b1; wrIdx = 4'(5 + $urandom % 2); wrData = $urandom;
      end
      dstValid = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: dstAddr = UC_BASE | 48'(8'h50 + $urandom % 10);
        1: dstAddr = BCAST;
        2: dstAddr = {16'($urandom) | 16'h0100, 32'($urandom)};
        default: dstAddr = {16'($urandom) & 16'hFEFF, 32'($urandom)};
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0; dstValid = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule